// File: doc/BRIEF.md
# Streaming Vector Reduction Unit

This block folds a vector of signed integers, presented one element per clock, into a single scalar. Four reductions are available: the signed sum, the smallest value, the largest value, and pivot search. Pivot search reports the position of the element with the greatest magnitude, which is what a row-exchange step in a matrix factorisation needs. Minimum and maximum also report the position of the winning element.

An operation is opened by a one-cycle `start_i` together with an opcode and an element count. The count may differ from one operation to the next; a typical factorisation loop issues each operation one element shorter than the one before. Elements are then offered with `elem_valid_i`, and idle cycles between them are allowed. The registered result appears with a one-cycle `done_o` pulse. It stays on the outputs until the next operation completes.

Top module: `vec_reduce`

## Requirements
- R1: With op_i = 0 (sum), result_o is the exact signed sum of the elements, sign-extended to ACC_W bits, for any MAX_LEN elements of any value; index_o is 0.
- R2: With op_i = 1 (minimum), result_o is the smallest element as a signed value, sign-extended, and index_o is its zero-based position.
- R3: With op_i = 2 (maximum), result_o is the largest element as a signed value, sign-extended, and index_o is its zero-based position.
- R4: With op_i = 3 (pivot), index_o is the position of the element with the largest absolute value, and result_o is that absolute value as a non-negative number; the most negative element has magnitude 2^(DATA_W-1).
- R5: When several elements tie for the winning key in minimum, maximum or pivot, index_o is the lowest such position.
- R6: done_o is high for exactly the one cycle after the clock edge that accepts the last element, with result_ok_o = 1. It is never high while elements are still expected, and result_o holds its value until the next done_o.
- R7: Cycles with elem_valid_i low are skipped. They change neither the element count nor the result.
- R8: A start with len_i = 0 raises done_o in the cycle after the start, with result_ok_o = 0, index_o = 0 and result_o = 0.
- R9: A start_i raised while an operation is in progress is ignored. The running operation keeps its opcode and count, and no extra done_o pulse follows.
- R10: A len_i above MAX_LEN is treated as MAX_LEN.
- R11: After reset, done_o, result_ok_o, result_o and index_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens an operation when the unit is idle |
| op_i | input | 2 | Reduction select: 0 sum, 1 minimum, 2 maximum, 3 pivot |
| len_i | input | LEN_W | Element count of the operation |
| elem_valid_i | input | 1 | Qualifies elem_i |
| elem_i | input | DATA_W | Signed element |
| result_o | output | ACC_W | Scalar result |
| index_o | output | IDX_W | Winning position (0 for sum and for an empty vector) |
| done_o | output | 1 | One-cycle completion pulse |
| result_ok_o | output | 1 | High when the completed operation held at least one element |

## Verification
The bench probes several corner cases, each tied to a specific error.

- **Magnitude ties and extremes.** Pivot vectors contain the most negative value, and pairs of equal magnitude with opposite signs. A comparator on raw signed values, or one that takes the later of two equal magnitudes, returns the wrong position.
- **Sum range.** Sums of a full-length vector of the most negative and of the most positive element reach the edges of the accumulator. A narrower accumulator would wrap.
- **Timing.** Gapped input, an oversize length, and a start raised mid-run all test the element counter. If the counter or the start gating is wrong, done_o arrives early or late, or a second done_o appears.
- **Empty and shrinking vectors.** An empty vector must complete without reporting a valid result. Shrinking pivot searches show that a stale best value from the previous operation does not leak into the next.

// File: rtl/vred_pkg.sv
package vred_pkg;
  typedef enum logic [1:0] {
    OP_SUM   = 2'd0,
    OP_MIN   = 2'd1,
    OP_MAX   = 2'd2,
    OP_PIVOT = 2'd3
  } vred_op_e;
endpackage

// File: rtl/vred_seq.sv
// Element sequencer: accepts a start when idle, counts accepted elements,
// and flags the first and last element of each operation.
module vred_seq #(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             elem_valid_i,
  output logic             busy_o,
  output logic             launch_o,
  output logic             empty_o,
  output logic             take_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic             busy_q;
  logic [LEN_W-1:0] remain_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff  = (len_i > LEN_CAP) ? LEN_CAP : len_i;
  assign launch_o = start_i & ~busy_q;
  assign empty_o  = launch_o & (len_eff == '0);
  assign take_o   = busy_q & elem_valid_i;
  assign first_o  = take_o & (idx_q == '0);
  assign last_o   = take_o & (remain_q == LEN_W'(1));
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      idx_q    <= '0;
    end else if (launch_o) begin
      busy_q   <= (len_eff != '0);
      remain_q <= len_eff;
      idx_q    <= '0;
    end else if (take_o) begin
      remain_q <= remain_q - LEN_W'(1);
      idx_q    <= idx_q + IDX_W'(1);
      if (remain_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vred_fold.sv
// Fold datapath: running key and best position, with the next values
// offered combinationally so the top can register them on the last element.
module vred_fold
  import vred_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 22,
  parameter int IDX_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  vred_op_e                 op_i,
  input  logic                     take_i,
  input  logic                     first_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic signed [DATA_W-1:0] elem_i,
  output logic signed [ACC_W-1:0]  nxt_acc_o,
  output logic [IDX_W-1:0]         nxt_idx_o
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic signed [ACC_W-1:0] acc_q;
  logic [IDX_W-1:0]        bidx_q;
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] key;
  logic                    better;

  assign ext = $signed({{EXT_W{elem_i[DATA_W-1]}}, elem_i});

  always_comb begin
    key    = (op_i == OP_PIVOT && elem_i[DATA_W-1]) ? -ext : ext;
    better = 1'b0;
    unique case (op_i)
      OP_MIN:   better = first_i || (key < acc_q);
      OP_MAX,
      OP_PIVOT: better = first_i || (key > acc_q);
      default:  better = 1'b0;
    endcase
    if (op_i == OP_SUM) begin
      nxt_acc_o = first_i ? ext : acc_q + ext;
      nxt_idx_o = '0;
    end else begin
      nxt_acc_o = better ? key : acc_q;
      nxt_idx_o = better ? idx_i : bidx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      bidx_q <= '0;
    end else if (take_i) begin
      acc_q  <= nxt_acc_o;
      bidx_q <= nxt_idx_o;
    end
  end
endmodule

// File: rtl/vec_reduce.sv
module vec_reduce
  import vred_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int ACC_W   = DATA_W + $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              elem_valid_i,
  input  logic [DATA_W-1:0] elem_i,
  output logic [ACC_W-1:0]  result_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              done_o,
  output logic              result_ok_o
);
  vred_op_e                op_q;
  logic                    seq_busy, seq_launch, seq_empty;
  logic                    seq_take, seq_first, seq_last;
  logic [IDX_W-1:0]        seq_idx;
  logic signed [ACC_W-1:0] fold_acc;
  logic [IDX_W-1:0]        fold_idx;

  vred_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .elem_valid_i(elem_valid_i), .busy_o(seq_busy), .launch_o(seq_launch),
    .empty_o(seq_empty), .take_o(seq_take), .first_o(seq_first),
    .last_o(seq_last), .idx_o(seq_idx)
  );

  vred_fold #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_fold (
    .clk(clk), .rst(rst), .op_i(op_q), .take_i(seq_take),
    .first_i(seq_first), .idx_i(seq_idx), .elem_i($signed(elem_i)),
    .nxt_acc_o(fold_acc), .nxt_idx_o(fold_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= OP_SUM;
      result_o    <= '0;
      index_o     <= '0;
      done_o      <= 1'b0;
      result_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (seq_launch) op_q <= vred_op_e'(op_i);
      if (seq_empty) begin
        result_o    <= '0;
        index_o     <= '0;
        done_o      <= 1'b1;
        result_ok_o <= 1'b0;
      end else if (seq_last) begin
        result_o    <= fold_acc;
        index_o     <= fold_idx;
        done_o      <= 1'b1;
        result_ok_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vred_chk.sv
module vred_chk
  import vred_pkg::*;
#(
  parameter int ACC_W = 22,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             seq_busy,
  input logic             seq_empty,
  input logic             seq_last,
  input vred_op_e         op_q,
  input logic [ACC_W-1:0] result_o,
  input logic [IDX_W-1:0] index_o,
  input logic             done_o,
  input logic             result_ok_o
);
  AST_EMPTY_RESULT: assert property (@(posedge clk) disable iff (rst)
    seq_empty |=> done_o && !result_ok_o && index_o == '0 && result_o == '0); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    seq_last |=> done_o && result_ok_o); // R6
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    seq_busy |-> !done_o); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    seq_busy && start_i |=> $stable(op_q)); // R9
  AST_PIVOT_NONNEG: assert property (@(posedge clk) disable iff (rst)
    done_o && result_ok_o && op_q == OP_PIVOT |-> !result_o[ACC_W-1]); // R4
  AST_SUM_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_o && op_q == OP_SUM |-> index_o == '0); // R1
endmodule

bind vec_reduce vred_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .seq_busy(seq_busy),
  .seq_empty(seq_empty), .seq_last(seq_last), .op_q(op_q),
  .result_o(result_o), .index_o(index_o), .done_o(done_o),
  .result_ok_o(result_ok_o)
);

// File: tb/tb_vec_reduce.sv
module tb_vec_reduce;
  localparam int DATA_W  = 16;
  localparam int MAX_LEN = 64;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int ACC_W   = DATA_W + $clog2(MAX_LEN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [LEN_W-1:0] len_i = '0;
  logic elem_valid_i = 1'b0;
  logic [DATA_W-1:0] elem_i = '0;
  logic [ACC_W-1:0] result_o;
  logic [IDX_W-1:0] index_o;
  logic done_o, result_ok_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  longint exp_res;
  longint exp_idx;
  logic signed [DATA_W-1:0] mem [0:127];

  always #10 clk = ~clk;

  vec_reduce #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .len_i(len_i),
    .elem_valid_i(elem_valid_i), .elem_i(elem_i), .result_o(result_o),
    .index_o(index_o), .done_o(done_o), .result_ok_o(result_ok_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(input int op, input int n);
    longint s = 0;
    longint best = 0;
    int bi = 0;
    for (int i = 0; i < n; i++) begin
      longint v = longint'(mem[i]);
      longint k = (op == 3 && v < 0) ? -v : v;
      s += v;
      if (i == 0 || (op == 1 ? (k < best) : (k > best))) begin
        best = k;
        bi = i;
      end
    end
    exp_res = (op == 0) ? s : best;
    exp_idx = (op == 0) ? 0 : bi;
  endfunction

  // Runs one operation of n elements; checks done timing and results.
  task automatic run_op(input int op, input int len, input int n, input bit gaps,
                        input string req);
    @(negedge clk);
    start_i = 1'b1; op_i = 2'(op); len_i = LEN_W'(len);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      elem_valid_i = 1'b1;
      elem_i = mem[i];
      @(negedge clk);
      if (i == n - 1) elem_valid_i = 1'b0;
      else begin
        chk({req, " no early done"}, longint'(done_o), 0);
        if (gaps) begin
          elem_valid_i = 1'b0;
          elem_i = 16'h7fff;
          @(negedge clk);
        end
      end
    end
    model(op, n);
    chk({req, " done"}, longint'(done_o), 1);
    chk({req, " ok"}, longint'(result_ok_o), 1);
    chk({req, " result"}, longint'($signed(result_o)), exp_res);
    chk({req, " index"}, longint'(index_o), exp_idx);
    @(negedge clk);
    chk({req, " done pulse one cycle (R6)"}, longint'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R11 done", longint'(done_o), 0);
    chk("R11 ok", longint'(result_ok_o), 0);
    chk("R11 result", longint'(result_o), 0);
    chk("R11 index", longint'(index_o), 0);
  endtask

  task automatic t_sum();
    mem[0] = 100; mem[1] = -250; mem[2] = 7; mem[3] = 32767; mem[4] = -32768;
    run_op(0, 5, 5, 0, "R1 mixed sum");
    for (int i = 0; i < MAX_LEN; i++) mem[i] = -16'sd32768;
    run_op(0, MAX_LEN, MAX_LEN, 0, "R1 full negative sum");
    for (int i = 0; i < MAX_LEN; i++) mem[i] = 16'sd32767;
    run_op(0, MAX_LEN, MAX_LEN, 0, "R1 full positive sum");
  endtask

  task automatic t_minmax();
    mem[0] = 5; mem[1] = -9; mem[2] = 40; mem[3] = -9; mem[4] = 40; mem[5] = 0;
    run_op(1, 6, 6, 0, "R2 R5 min with tie");
    run_op(2, 6, 6, 0, "R3 R5 max with tie");
  endtask

  task automatic t_pivot();
    mem[0] = 3; mem[1] = 32767; mem[2] = -32768; mem[3] = -32768; mem[4] = 1;
    run_op(3, 5, 5, 0, "R4 R5 pivot most negative");
    mem[0] = 0; mem[1] = -5; mem[2] = 5; mem[3] = 4; mem[4] = -5;
    run_op(3, 5, 5, 0, "R4 R5 pivot sign tie");
    // shrinking pivot searches: a stale best must not carry over
    for (int i = 0; i < 8; i++) mem[i] = DATA_W'(10 * (8 - i));
    mem[0] = -200;
    run_op(3, 8, 8, 0, "R4 pivot len 8");
    for (int i = 0; i < 7; i++) mem[i] = mem[i + 1];
    run_op(3, 7, 7, 0, "R4 pivot len 7");
    for (int i = 0; i < 6; i++) mem[i] = mem[i + 1];
    run_op(3, 6, 6, 0, "R4 pivot len 6");
  endtask

  task automatic t_gaps();
    mem[0] = 11; mem[1] = -3; mem[2] = 20; mem[3] = 1;
    run_op(0, 4, 4, 1, "R7 gapped sum");
    run_op(2, 4, 4, 1, "R7 gapped max");
  endtask

  task automatic t_zero();
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd3; len_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 done", longint'(done_o), 1);
    chk("R8 ok low", longint'(result_ok_o), 0);
    chk("R8 index", longint'(index_o), 0);
    chk("R8 result", longint'(result_o), 0);
    @(negedge clk);
    chk("R8 single pulse", longint'(done_o), 0);
  endtask

  task automatic t_busy_start();
    mem[0] = 4; mem[1] = -6; mem[2] = 9;
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd0; len_i = LEN_W'(3);
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd1; len_i = '0;
    elem_valid_i = 1'b1; elem_i = mem[0];
    @(negedge clk);
    chk("R9 no done from restart", longint'(done_o), 0);
    start_i = 1'b0;
    elem_i = mem[1];
    @(negedge clk);
    chk("R9 still running", longint'(done_o), 0);
    elem_i = mem[2];
    @(negedge clk);
    elem_valid_i = 1'b0;
    chk("R9 done", longint'(done_o), 1);
    chk("R9 sum kept", longint'($signed(result_o)), 7);
    @(negedge clk);
    chk("R9 no extra done", longint'(done_o), 0);
  endtask

  task automatic t_clamp();
    for (int i = 0; i < MAX_LEN; i++) mem[i] = 16'sd1;
    run_op(0, 100, MAX_LEN, 0, "R10 clamped length");
  endtask

  task automatic t_hold();
    longint held = longint'($signed(result_o));
    repeat (4) @(negedge clk);
    chk("R6 result held", longint'($signed(result_o)), held);
    chk("R6 done low while idle", longint'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_sum();
    t_minmax();
    t_pivot();
    t_gaps();
    t_zero();
    t_busy_start();
    t_clamp();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule